// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Start

This block is the address front end of a synchronous burst memory. On every rising clock edge it samples an external address, three chip enables, two active-low start strobes (one driven by a processor, one by a memory controller), an active-low advance input and an active-low write request. From these it keeps a base address and a 2-bit beat counter. It reports the array address for the current cycle, whether the device is selected, and what kind of cycle is under way: begin, continue, suspend or deselect.

The two strobes follow different enable rules. The processor strobe is masked entirely while the first enable is inactive. It always starts a read. The controller strobe starts a cycle whatever the first enable is, and it takes read or write from the write request. While no strobe is active, the advance input either steps the burst or holds it for a wait cycle. A static order input chooses how the counter is folded into the two low address bits: as a sum or as an XOR. The registered outputs feed a downstream data-path block.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, the outputs are: selected 0, deselect 1, cycle type 0 (deselect), write 0, forced-read 0, and array address 0.
- R2: A processor start is processor strobe low with first enable low (active). If the second enable is high and the third enable is low, the next cycle is a begin cycle (code 1) with selected 1 and forced-read 1. Write is 0 whatever the write request is. The base is loaded with the whole external address and the beat counter is cleared.
- R3: A controller start is controller strobe low without a processor start. If all three enables are active, the next cycle is a begin cycle (code 1). Write equals the inverted write request and forced-read is 0.
- R4: While the first enable is high, a low processor strobe is ignored. With the controller strobe high, the cycle runs as a continue or suspend cycle. With the controller strobe low, the cycle is a deselect.
- R5: At any start, second enable low or third enable high gives a deselect cycle (code 0, selected 0, deselect 1, write 0).
- R6: With the device selected, both strobes high and advance low, the counter steps by one. The cycle type is continue (code 2) and write equals the inverted write request.
- R7: With the device selected, both strobes high and advance high, the cycle is a suspend (code 3). The array address is held and write equals the inverted write request.
- R8: With the order input low (linear), the two low array address bits are (base low bits + count) modulo 4.
- R9: With the order input high (interleaved), the two low array address bits are base low bits XOR count.
- R10: The counter wraps after four beats and keeps cycling while advance stays low. No beat ends the burst by itself.
- R11: While deselected, cycles without a start stay deselected (code 0, write 0) and leave the address unchanged.
- R12: The array address bits above the two low bits always equal those of the base loaded at the last selected start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address, loaded at a selected start |
| ce_a_n | input | 1 | First chip enable, active low; masks the processor strobe |
| ce_b | input | 1 | Second chip enable, active high, sampled only at starts |
| ce_c_n | input | 1 | Third chip enable, active low, sampled only at starts |
| strobe_cpu_n | input | 1 | Processor start strobe, active low |
| strobe_ctl_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Advance, active low; high suspends the burst |
| wr_n | input | 1 | Combined write request, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| arr_addr | output | ADDR_W | Array address for the current cycle |
| sel | output | 1 | Device selected |
| desel | output | 1 | Deselect cycle flag |
| cyc_type | output | 2 | 0 deselect, 1 begin, 2 continue, 3 suspend |
| is_write | output | 1 | Current cycle writes |
| force_rd | output | 1 | Begin cycle forced to read by a processor start |

## Verification
A wrong count or a bad base register shows on the two low address bits within one cycle of the beat concerned. A stuck counter shows on the second continue beat. A missed wrap shows on the fifth beat. A wrong start decode shows on the selected flag and the cycle type in the cycle right after the strobe edge, and a selection held in error shows on the first cycle with no start after a deselect. The bench keeps an arithmetic model of base and count for both orders, all four start offsets and both strobes, and compares every output after every edge.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              wr_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              sel,
  output logic              desel,
  output logic [1:0]        cyc_type,
  output logic              is_write,
  output logic              force_rd
);
  localparam logic [1:0] CY_DESEL = 2'd0;
  localparam logic [1:0] CY_BEGIN = 2'd1;
  localparam logic [1:0] CY_CONT  = 2'd2;
  localparam logic [1:0] CY_SUSP  = 2'd3;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lo_bits;

  wire cpu_go   = !strobe_cpu_n && !ce_a_n;
  wire start    = cpu_go || !strobe_ctl_n;
  wire ena_ok   = !ce_a_n && ce_b && !ce_c_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      sel      <= 1'b0;
      cyc_type <= CY_DESEL;
      is_write <= 1'b0;
      force_rd <= 1'b0;
    end else if (start) begin
      if (ena_ok) begin
        base_q   <= addr_in;
        cnt_q    <= '0;
        sel      <= 1'b1;
        cyc_type <= CY_BEGIN;
        force_rd <= cpu_go;
        is_write <= cpu_go ? 1'b0 : !wr_n;
      end else begin
        sel      <= 1'b0;
        cyc_type <= CY_DESEL;
        force_rd <= 1'b0;
        is_write <= 1'b0;
      end
    end else if (sel) begin
      force_rd <= 1'b0;
      is_write <= !wr_n;
      if (!adv_n) begin
        cnt_q    <= cnt_q + 1'b1;
        cyc_type <= CY_CONT;
      end else begin
        cyc_type <= CY_SUSP;
      end
    end else begin
      cyc_type <= CY_DESEL;
      force_rd <= 1'b0;
      is_write <= 1'b0;
    end
  end

  assign lo_bits  = order_sel ? (base_q[CNT_W-1:0] ^ cnt_q)
                              : (base_q[CNT_W-1:0] + cnt_q);
  assign arr_addr = {base_q[ADDR_W-1:CNT_W], lo_bits};
  assign desel    = !sel;
endmodule

module burst_addr_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_a_n,
  input logic              ce_b,
  input logic              ce_c_n,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              sel,
  input logic [1:0]        cyc_type,
  input logic              is_write,
  input logic              force_rd
);
  a_r2_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && !ce_a_n && ce_b && !ce_c_n) |=> (sel && force_rd && !is_write && cyc_type == 2'd1));

  a_r4_masked_ctl_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_a_n && !strobe_ctl_n) |=> (!sel && cyc_type == 2'd0));

  a_r6_continue_type: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu_n && strobe_ctl_n && !adv_n && sel) |=> (sel && cyc_type == 2'd2));

  a_r7_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu_n && strobe_ctl_n && adv_n && sel) |=> (cyc_type == 2'd3 && (!$stable(order_sel) || $stable(arr_addr))));

  a_r11_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!is_write && cyc_type == 2'd0));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
  .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
  .order_sel(order_sel), .arr_addr(arr_addr), .sel(sel), .cyc_type(cyc_type),
  .is_write(is_write), .force_rd(force_rd)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 18;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr_in = '0;
  logic ce_a_n = 1, ce_b = 0, ce_c_n = 1, strobe_cpu_n = 1, strobe_ctl_n = 1;
  logic adv_n = 1, wr_n = 1, order_sel = 1;
  logic [AW-1:0] arr_addr;
  logic sel, desel, is_write, force_rd;
  logic [1:0] cyc_type;
  int errs = 0, checks = 0;

  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = 0, m_cyc = 0;
  logic m_sel = 0, m_wr = 0, m_frd = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = order_sel ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic compare(string tag);
    chk(tag, "sel", sel, m_sel);
    chk(tag, "desel", desel, !m_sel);
    chk(tag, "cyc", cyc_type, m_cyc);
    chk(tag, "wr", is_write, m_wr);
    chk(tag, "frd", force_rd, m_frd);
    chk(tag, "addr", arr_addr, m_addr());
  endtask

  task automatic step(string tag, logic cpu, logic ctl, logic adv, logic a, logic b,
                      logic c, logic w, logic [AW-1:0] ad);
    logic go_cpu, go;
    @(negedge clk);
    strobe_cpu_n = cpu; strobe_ctl_n = ctl; adv_n = adv;
    ce_a_n = a; ce_b = b; ce_c_n = c; wr_n = w; addr_in = ad;
    go_cpu = !cpu && !a;
    go = go_cpu || !ctl;
    if (go) begin
      if (!a && b && !c) begin
        m_base = ad; m_cnt = 0; m_sel = 1; m_cyc = 1;
        m_frd = go_cpu; m_wr = go_cpu ? 1'b0 : !w;
      end else begin
        m_sel = 0; m_cyc = 0; m_frd = 0; m_wr = 0;
      end
    end else if (m_sel) begin
      m_frd = 0; m_wr = !w;
      if (!adv) begin m_cnt = m_cnt + 1; m_cyc = 2; end
      else m_cyc = 3;
    end else begin
      m_cyc = 0; m_frd = 0; m_wr = 0;
    end
    @(posedge clk); #1;
    compare(tag);
  endtask

  initial begin
    #500000;
    errs++; checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    compare("R1");
    rst_n = 1;

    // R2 R3 R8 R9 R10 R12: every order, start offset and strobe, with wrap
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 2; k++) begin
          logic [AW-1:0] ad;
          string ot;
          order_sel = m[0];
          ot = m ? "R9" : "R8";
          ad = {16'(16'h2A5 * (s + 1) + k * 16'h1111), s[1:0]};
          if (k == 0) step("R2", 0, 0, 1, 0, 1, 0, 0, ad);
          else        step("R3", 1, 0, 1, 0, 1, 0, s[0], ad);
          step(ot, 1, 1, 0, 0, 1, 0, 1, '0);
          step("R7", 1, 1, 1, 0, 1, 0, 0, '1);
          step("R6", 1, 1, 0, 1, 0, 1, 0, '0);
          step(ot, 1, 1, 0, 0, 1, 0, 1, '0);
          step("R10", 1, 1, 0, 0, 1, 0, 1, '0);
          step("R10", 1, 1, 0, 0, 1, 0, 0, '0);
          step("R12", 1, 1, 1, 0, 1, 0, 1, '0);
        end

    order_sel = 0;
    step("R3", 1, 0, 1, 0, 1, 0, 1, 18'h1_2343);
    // R4: processor strobe masked by first enable, burst continues
    step("R4", 0, 1, 0, 1, 1, 0, 1, 18'h3_0000);
    step("R4", 0, 1, 1, 1, 1, 0, 1, 18'h3_0000);
    // R4: first enable high with controller strobe low deselects
    step("R4", 1, 0, 0, 1, 1, 0, 0, 18'h3_0000);
    // R11: stays deselected without a start
    step("R11", 1, 1, 0, 0, 1, 0, 0, 18'h0_1111);
    step("R11", 1, 1, 1, 0, 1, 0, 0, 18'h0_1111);
    step("R11", 0, 1, 0, 1, 1, 0, 0, 18'h0_1111);
    // R5: second or third enable inactive at a start
    step("R3", 1, 0, 1, 0, 1, 0, 1, 18'h0_0002);
    step("R5", 0, 1, 1, 0, 0, 0, 1, 18'h2_2222);
    step("R11", 1, 1, 0, 0, 1, 0, 1, '0);
    step("R3", 1, 0, 1, 0, 1, 0, 0, 18'h0_0001);
    step("R5", 1, 0, 1, 0, 1, 1, 0, 18'h2_2222);
    step("R5", 0, 0, 1, 0, 1, 1, 0, 18'h2_2222);
    // R2: processor start overrides a write request
    step("R2", 0, 1, 0, 0, 1, 0, 0, 18'h3_FFFF);
    step("R6", 1, 1, 0, 0, 1, 0, 0, '0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule